// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two IEEE-754 values, a left operand `d` and a right operand `m`. It returns a four-bit condition result in N/Z/C/V form and an invalid-operation flag. Both results are computed directly from the packed bit patterns. No unpacking into an arithmetic datapath takes place.

A per-request input selects the precision. With 32-bit format the operands are taken from the low half of the 64-bit buses, and with 64-bit format the whole bus is used. A second input chooses between the signalling compare and the quiet compare. A third input replaces `m` with positive zero for compare-against-zero.

The new flags are merged into bits 31..28 of a caller-supplied status word. The result is registered and appears one clock after the request.

Top module: `fcmp_flag_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones (8 bits at [30:23] for 32-bit, 11 bits at [62:52] for 64-bit) and its fraction is nonzero. If either operand is a NaN, the flags are unordered: N=0, Z=0, C=1, V=1 (`flags` = 4'b0011, bit order N,Z,C,V from bit 3 down).
- R2: With `sig_cmp`=0 (quiet compare), `invalid` is 1 only if an operand is a signalling NaN, meaning a NaN whose fraction MSB (bit 22 or bit 51) is 0.
- R3: With `sig_cmp`=1 (signalling compare), `invalid` is 1 whenever either operand is a NaN, quiet or signalling.
- R4: Equal operands give `flags` = 4'b0110 (Z and C). Positive zero and negative zero compare equal.
- R5: If the operands are ordered, not equal, and of opposite sign, a negative `d` gives 4'b1000 (N, d < m) and a positive `d` gives 4'b0010 (C, d > m).
- R6: If the operands are ordered, not equal, and of the same sign, their magnitude fields are compared as unsigned integers. The outcome is reversed when both operands are negative. Less-than gives 4'b1000 and greater-than gives 4'b0010.
- R7: With `dbl_sel`=0 only bits [31:0] of each operand are used, and bits [63:32] have no effect. With `dbl_sel`=1 all 64 bits are used.
- R8: With `cmp_zero`=1 the `op_m` bus is ignored and an all-zero pattern is used as the right operand. The NaN and invalid rules still apply to `d`.
- R9: `status_out` places N,Z,C,V at bits 31,30,29,28. Bits 27..0 are copied from the `status_in` presented with the request.
- R10: A request sampled with `in_valid`=1 produces `out_valid`=1 and its results on the next clock. Without a request, `out_valid` is 0 and the other outputs hold. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| dbl_sel | input | 1 | 1 = 64-bit format, 0 = 32-bit format in low half |
| sig_cmp | input | 1 | 1 = signalling compare, 0 = quiet compare |
| cmp_zero | input | 1 | 1 = compare `d` against positive zero |
| op_d | input | 64 | Left operand |
| op_m | input | 64 | Right operand |
| status_in | input | 32 | Status word whose flag field is replaced |
| out_valid | output | 1 | Result strobe, one clock after the request |
| flags | output | 4 | N,Z,C,V (bit 3 down to bit 0) |
| invalid | output | 1 | Invalid-operation exception |
| status_out | output | 32 | Merged status word |

## Verification
The unordered outcome and the invalid exception come from separate paths, and both fire in the same cycle when a NaN meets a signalling compare or when a signalling NaN appears in either mode. The bench provokes this by pairing quiet and signalling NaNs with every other operand class, in both precisions and both compare modes. A scoreboard reference predicts both results from real-valued comparison and field inspection, and checks flags, the exception and the merged status word together on each result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int MAG_W    = DP_EXP_W + DP_MAN_W;

  typedef logic [3:0] nzcv_t;

  localparam nzcv_t FL_UNORD = 4'b0011;
  localparam nzcv_t FL_EQ    = 4'b0110;
  localparam nzcv_t FL_LT    = 4'b1000;
  localparam nzcv_t FL_GT    = 4'b0010;

  typedef struct packed {
    logic             sign;
    logic             zero;
    logic             nan;
    logic             snan;
    logic [MAG_W-1:0] mag;
  } fcmp_class_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output fcmp_class_t          cls
);

  localparam int DW = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             man_nz;

  always_comb begin
    exp_f    = word[DW-2:MAN_W];
    man_f    = word[MAN_W-1:0];
    exp_ones = &exp_f;
    man_nz   = |man_f;

    cls            = '0;
    cls.sign       = word[DW-1];
    cls.zero       = (exp_f == '0) && !man_nz;
    cls.nan        = exp_ones && man_nz;
    cls.snan       = exp_ones && man_nz && !man_f[MAN_W-1];
    cls.mag[DW-2:0] = word[DW-2:0];
  end

endmodule

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
  import fcmp_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic        dbl_sel,
  input  logic [DW-1:0] word,
  output fcmp_class_t cls
);

  localparam int SP_W = SP_EXP_W + SP_MAN_W + 1;

  fcmp_class_t cls_sp;
  fcmp_class_t cls_dp;

  fcmp_classify #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp (
    .word (word[SP_W-1:0]),
    .cls  (cls_sp)
  );

  generate
    if (DW >= DP_EXP_W + DP_MAN_W + 1) begin : g_dp
      fcmp_classify #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp (
        .word (word[DP_EXP_W+DP_MAN_W:0]),
        .cls  (cls_dp)
      );
    end else begin : g_no_dp
      assign cls_dp = cls_sp;
    end
  endgenerate

  assign cls = dbl_sel ? cls_dp : cls_sp;

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
(
  input  fcmp_class_t cls_d,
  input  fcmp_class_t cls_m,
  input  logic        sig_cmp,
  output nzcv_t       nzcv,
  output logic        inv
);

  logic unord;
  logic same_bits;
  logic both_zero;
  logic mag_lt;

  always_comb begin
    unord     = cls_d.nan | cls_m.nan;
    same_bits = (cls_d.sign == cls_m.sign) && (cls_d.mag == cls_m.mag);
    both_zero = cls_d.zero & cls_m.zero;
    mag_lt    = cls_d.mag < cls_m.mag;
    inv       = cls_d.snan | cls_m.snan | (sig_cmp & unord);

    if (unord) begin
      nzcv = FL_UNORD;
    end else if (same_bits || both_zero) begin
      nzcv = FL_EQ;
    end else if (cls_d.sign != cls_m.sign) begin
      nzcv = cls_d.sign ? FL_LT : FL_GT;
    end else if (mag_lt ^ cls_d.sign) begin
      nzcv = FL_LT;
    end else begin
      nzcv = FL_GT;
    end
  end

endmodule

// File: rtl/fcmp_merge.sv
module fcmp_merge
  import fcmp_pkg::*;
#(
  parameter int SW       = 32,
  parameter int FLAG_POS = 28
) (
  input  logic [SW-1:0] status_in,
  input  nzcv_t         nzcv,
  output logic [SW-1:0] status_out
);

  localparam int TOP = FLAG_POS + 4;

  logic [SW-1:0] cleared;

  always_comb begin
    cleared = status_in;
    if (|nzcv) begin
      cleared[TOP-1:FLAG_POS] = '0;
    end
    status_out = cleared;
    status_out[TOP-1:FLAG_POS] = cleared[TOP-1:FLAG_POS] | nzcv;
  end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int STAT_W   = 32,
  parameter int FLAG_POS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              dbl_sel,
  input  logic              sig_cmp,
  input  logic              cmp_zero,
  input  logic [DATA_W-1:0] op_d,
  input  logic [DATA_W-1:0] op_m,
  input  logic [STAT_W-1:0] status_in,
  output logic              out_valid,
  output logic [3:0]        flags,
  output logic              invalid,
  output logic [STAT_W-1:0] status_out
);

  logic [DATA_W-1:0] m_eff;
  fcmp_class_t       cls_d;
  fcmp_class_t       cls_m;
  nzcv_t             nzcv_c;
  logic              inv_c;
  logic [STAT_W-1:0] stat_c;

  logic              vld_q, vld_d;
  nzcv_t             fl_q, fl_d;
  logic              inv_q, inv_d;
  logic [STAT_W-1:0] st_q, st_d;

  assign m_eff = cmp_zero ? '0 : op_m;

  fcmp_unpack #(.DW(DATA_W)) u_unp_d (
    .dbl_sel (dbl_sel),
    .word    (op_d),
    .cls     (cls_d)
  );

  fcmp_unpack #(.DW(DATA_W)) u_unp_m (
    .dbl_sel (dbl_sel),
    .word    (m_eff),
    .cls     (cls_m)
  );

  fcmp_order u_order (
    .cls_d   (cls_d),
    .cls_m   (cls_m),
    .sig_cmp (sig_cmp),
    .nzcv    (nzcv_c),
    .inv     (inv_c)
  );

  fcmp_merge #(.SW(STAT_W), .FLAG_POS(FLAG_POS)) u_merge (
    .status_in  (status_in),
    .nzcv       (nzcv_c),
    .status_out (stat_c)
  );

  always_comb begin
    vld_d = in_valid;
    fl_d  = fl_q;
    inv_d = inv_q;
    st_d  = st_q;
    if (in_valid) begin
      fl_d  = nzcv_c;
      inv_d = inv_c;
      st_d  = stat_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      fl_q  <= '0;
      inv_q <= 1'b0;
      st_q  <= '0;
    end else begin
      vld_q <= vld_d;
      fl_q  <= fl_d;
      inv_q <= inv_d;
      st_q  <= st_d;
    end
  end

  assign out_valid  = vld_q;
  assign flags      = fl_q;
  assign invalid    = inv_q;
  assign status_out = st_q;

  AST_UNORD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[0] |-> flags == FL_UNORD); // R1
  AST_INV_ONLY_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && invalid |-> flags == FL_UNORD); // R2
  AST_SIG_NAN_INV: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sig_cmp && (cls_d.nan || cls_m.nan) |=> invalid); // R3
  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls_d.zero && cls_m.zero |=> flags == FL_EQ); // R4
  AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> status_out[FLAG_POS-1:0] == $past(status_in[FLAG_POS-1:0])); // R9
  AST_FLAG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> status_out[FLAG_POS+3:FLAG_POS] == flags); // R9
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(flags) && $stable(status_out) && !out_valid); // R10

endmodule

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        dbl_sel = 1'b0;
  logic        sig_cmp = 1'b0;
  logic        cmp_zero = 1'b0;
  logic [63:0] op_d = '0;
  logic [63:0] op_m = '0;
  logic [31:0] status_in = '0;
  logic        out_valid;
  logic [3:0]  flags;
  logic        invalid;
  logic [31:0] status_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [36:0] exp_q[$];
  string       req_q[$];
  logic [36:0] last_exp = '0;

  always #10 clk = ~clk;

  fcmp_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
    .sig_cmp(sig_cmp), .cmp_zero(cmp_zero), .op_d(op_d), .op_m(op_m),
    .status_in(status_in), .out_valid(out_valid), .flags(flags),
    .invalid(invalid), .status_out(status_out)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] pat(input bit dbl, input int i);
    logic [63:0] sp[11];
    logic [63:0] dp[11];
    sp = '{64'hDEADBEEF_00000000, 64'hDEADBEEF_80000000, 64'hDEADBEEF_00000001,
           64'hDEADBEEF_80400000, 64'hDEADBEEF_3F800000, 64'hDEADBEEF_BF800000,
           64'hDEADBEEF_40000000, 64'hDEADBEEF_7F800000, 64'hDEADBEEF_FF800000,
           64'hDEADBEEF_7FC00000, 64'hDEADBEEF_7F800001};
    dp = '{64'h0, 64'h8000000000000000, 64'h1, 64'h800F000000000000,
           64'h3FF0000000000000, 64'hBFF0000000000000, 64'h4000000000000000,
           64'h7FF0000000000000, 64'hFFF0000000000000, 64'h7FF8000000000000,
           64'h7FF0000000000001};
    return dbl ? dp[i] : sp[i];
  endfunction

  function automatic bit is_nan(input bit dbl, input logic [63:0] w);
    if (dbl) return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic bit is_snan(input bit dbl, input logic [63:0] w);
    return is_nan(dbl, w) && !(dbl ? w[51] : w[22]);
  endfunction

  function automatic real to_real(input bit dbl, input logic [63:0] w);
    real r;
    if (dbl) return $bitstoreal(w);
    if (w[30:23] == 8'hFF) return $bitstoreal({w[31], 11'h7FF, 52'h0});
    if (w[30:23] == 8'h00) r = real'(w[22:0]) * (2.0 ** (-149));
    else r = (8388608.0 + real'(w[22:0])) * (2.0 ** (real'(w[30:23]) - 150.0));
    return w[31] ? -r : r;
  endfunction

  task automatic send(input bit dbl, input bit sig, input bit zro,
                      input logic [63:0] d, input logic [63:0] m, input logic [31:0] st);
    logic [63:0] me;
    logic [3:0]  fl;
    logic        inv;
    string       req;
    real         rd, rm;
    me = zro ? 64'h0 : m;
    if (is_nan(dbl, d) || is_nan(dbl, me)) begin
      fl  = 4'b0011;
      req = "R1";
    end else begin
      rd = to_real(dbl, d);
      rm = to_real(dbl, me);
      if (rd == rm) begin fl = 4'b0110; req = "R4"; end
      else if (rd < rm) begin fl = 4'b1000; req = (d[dbl ? 63 : 31] != me[dbl ? 63 : 31]) ? "R5" : "R6"; end
      else begin fl = 4'b0010; req = (d[dbl ? 63 : 31] != me[dbl ? 63 : 31]) ? "R5" : "R6"; end
    end
    inv = is_snan(dbl, d) || is_snan(dbl, me) || (sig && (is_nan(dbl, d) || is_nan(dbl, me)));
    if (zro) req = {req, " R8"};
    if (!dbl) req = {req, " R7"};
    req = {req, sig ? " R3" : " R2"};
    @(negedge clk);
    in_valid  = 1'b1;
    dbl_sel   = dbl;
    sig_cmp   = sig;
    cmp_zero  = zro;
    op_d      = d;
    op_m      = m;
    status_in = st;
    exp_q.push_back({fl, inv, {fl, st[27:0]}});
    req_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", {63'h0, out_valid}, 64'h0);
      end else begin
        logic [36:0] e;
        string       r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        last_exp = e;
        check(flags == e[36:33], {r, " flags"}, {60'h0, flags}, {60'h0, e[36:33]});
        check(invalid == e[32], {r, " invalid"}, {63'h0, invalid}, {63'h0, e[32]});
        check(status_out == e[31:0], "R9 status", {32'h0, status_out}, {32'h0, e[31:0]});
      end
    end
  end

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    check(1'b0, "watchdog timeout", 64'h0, 64'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0 && flags == 4'h0 && invalid == 1'b0 && status_out == 32'h0,
          "R10 reset", {out_valid, flags, invalid, status_out}, 64'h0);

    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 11; i++)
          for (int j = 0; j < 11; j++) begin
            idx++;
            send(p[0], s[0], 1'b0, pat(p[0], i), pat(p[0], j), 32'h9E3779B9 * idx);
          end

    // R8: compare-with-zero, right bus carries a NaN that must be ignored
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 11; i++) begin
          idx++;
          send(p[0], s[0], 1'b1, pat(p[0], i), 64'h7FF0000000000001 | 64'h7F800001_7F800001,
               32'h9E3779B9 * idx);
        end

    // R7: upper half of single operands must not matter
    send(1'b0, 1'b0, 1'b0, 64'h0000000040000000, 64'hFFFFFFFF3F800000, 32'h0);
    send(1'b0, 1'b0, 1'b0, 64'h7FF80000BF800000, 64'h0000000000000000, 32'hFFFFFFFF);

    idle(3);
    // R10: outputs hold with no request
    check(out_valid == 1'b0, "R10 idle valid", {63'h0, out_valid}, 64'h0);
    check(flags == last_exp[36:33] && status_out == last_exp[31:0], "R10 hold",
          {28'h0, flags, status_out}, {28'h0, last_exp[36:33], last_exp[31:0]});
    check(exp_q.size() == 0, "R10 results outstanding", 64'(exp_q.size()), 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule